// File: doc/BRIEF.md
# Second-Chance Clock Victim Selector

This block tracks a usage flag and a modified flag for every physical page frame and, when asked, chooses a frame to evict by the clock (second-chance) policy. Each access presented on the access port marks its frame as recently used. A write access also marks the frame as modified.

A victim request starts a sweep from the current hand position. At each frame the hand reaches, a recently-used mark is removed and the frame is passed over. The first unmarked frame is chosen. The block returns the chosen frame index and a flag that says whether the old contents must be written back before the frame is reused.

Once chosen, the frame's marks are cleared for the incoming page. The hand then rests on the next frame. Page loading and table updates are handled elsewhere.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset every frame's use mark and modified mark are 0, the hand rests on frame 0, and `vic_valid` is 0; a first request therefore returns frame 0, not dirty, after one sweep step.
- R2: An access (`acc_valid` high) sets the use mark of frame `acc_idx`, whether or not `acc_write` is high.
- R3: During a sweep, a frame under the hand whose use mark is 1 has that mark cleared and is passed over; each frame takes one clock cycle.
- R4: The first frame under the hand with use mark 0 is chosen; `vic_valid` pulses high for exactly one cycle with `vic_idx` equal to that frame, in the cycle after its sweep step.
- R5: An access with `acc_write` high sets that frame's modified mark; `vic_dirty` reports the chosen frame's modified mark (1 = write-back needed).
- R6: The hand moves by one frame per sweep step, wrapping from frame NUM_FRAMES-1 to frame 0, and does not move outside a sweep; after a choice it rests on the frame after the victim.
- R7: With no access during a sweep, `vic_valid` rises no later than NUM_FRAMES+1 sweep steps after the request is taken.
- R8: Choosing a frame clears both its use mark and its modified mark.
- R9: If an access targets the frame under the hand in the same cycle as its sweep step, the access wins: the frame is passed over and its use mark stays 1.
- R10: `vic_req` is ignored while a sweep is in progress; one request yields exactly one `vic_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Frame access strobe |
| acc_idx | input | IDX_W | Index of the frame accessed |
| acc_write | input | 1 | Access is a write (sets the modified mark) |
| vic_req | input | 1 | Start a victim sweep (taken only when idle) |
| vic_valid | output | 1 | One-cycle pulse: victim chosen |
| vic_idx | output | IDX_W | Index of the chosen frame |
| vic_dirty | output | 1 | Chosen frame needs write-back |

## Verification
The two functions that can meet in one cycle are the sweep step and an access to the frame that the hand is examining at that moment. The bench provokes this by driving an access to the hand's frame in the exact cycle of the first sweep step. It checks that this frame is passed over and that the next frame is returned after two cycles. It then marks every other frame and sweeps again. Here it expects the kept mark to force one more pass over that frame, so the selection lands on the following frame after eight steps and never on the contested one.

// File: rtl/clock_victim_pkg.sv
`timescale 1ns/1ps
package clock_victim_pkg;
  typedef enum logic [0:0] {
    SWEEP_IDLE = 1'b0,
    SWEEP_RUN  = 1'b1
  } sweep_state_e;
endpackage

// File: rtl/victim_frame_bits.sv
`timescale 1ns/1ps
module victim_frame_bits #(
  parameter int NUM_FRAMES = 8,
  parameter int IDX_W      = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_valid,
  input  logic [IDX_W-1:0]      acc_idx,
  input  logic                  acc_write,
  input  logic                  step_valid,
  input  logic                  take_valid,
  input  logic [IDX_W-1:0]      sel_idx,
  output logic [NUM_FRAMES-1:0] use_vec,
  output logic [NUM_FRAMES-1:0] mod_vec
);

  logic [NUM_FRAMES-1:0] hit;
  logic [NUM_FRAMES-1:0] under_hand;
  logic [NUM_FRAMES-1:0] use_en;
  logic [NUM_FRAMES-1:0] use_d;
  logic [NUM_FRAMES-1:0] mod_en;
  logic [NUM_FRAMES-1:0] mod_d;
  logic [NUM_FRAMES-1:0] use_q;
  logic [NUM_FRAMES-1:0] mod_q;

  // Per-frame next-state: an access always wins over the sweep.
  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
    assign hit[g]        = acc_valid && (acc_idx == IDX_W'(g));
    assign under_hand[g] = (sel_idx == IDX_W'(g));
    assign use_en[g]     = hit[g] || (step_valid && under_hand[g]);
    assign use_d[g]      = hit[g];
    assign mod_en[g]     = (hit[g] && acc_write) || (take_valid && under_hand[g]);
    assign mod_d[g]      = hit[g] && acc_write;

    AST_ACC_SETS_USE: assert property (@(posedge clk) disable iff (!rst_n)
      hit[g] |=> use_q[g]); // R2
    AST_WR_SETS_MOD: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[g] && acc_write) |=> mod_q[g]); // R5
    AST_PASS_CLEARS_USE: assert property (@(posedge clk) disable iff (!rst_n)
      (step_valid && !take_valid && under_hand[g] && !hit[g]) |=> !use_q[g]); // R3
    AST_COLLIDE_KEEPS_USE: assert property (@(posedge clk) disable iff (!rst_n)
      (step_valid && under_hand[g] && hit[g]) |=> use_q[g]); // R9
    AST_TAKE_CLEARS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      (take_valid && under_hand[g]) |=> (!use_q[g] && !mod_q[g])); // R8
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      use_q <= '0;
      mod_q <= '0;
    end else begin
      for (int i = 0; i < NUM_FRAMES; i++) begin
        if (use_en[i]) use_q[i] <= use_d[i];
        if (mod_en[i]) mod_q[i] <= mod_d[i];
      end
    end
  end

  assign use_vec = use_q;
  assign mod_vec = mod_q;

endmodule

// File: rtl/victim_hand_ctrl.sv
`timescale 1ns/1ps
module victim_hand_ctrl
  import clock_victim_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  parameter int IDX_W      = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  vic_req,
  input  logic                  acc_valid,
  input  logic [IDX_W-1:0]      acc_idx,
  input  logic [NUM_FRAMES-1:0] use_vec,
  input  logic [NUM_FRAMES-1:0] mod_vec,
  output logic                  step_valid,
  output logic                  take_valid,
  output logic [IDX_W-1:0]      sel_idx,
  output logic                  vic_valid,
  output logic [IDX_W-1:0]      vic_idx,
  output logic                  vic_dirty
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FRAMES - 1);
  localparam int               CNT_W    = $clog2(NUM_FRAMES + 2) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] STEP_LIM = CNT_W'(NUM_FRAMES);

  sweep_state_e     state_q, state_d;
  logic [IDX_W-1:0] hand_q, hand_d;
  logic             vv_q, vv_d;
  logic [IDX_W-1:0] vidx_q, vidx_d;
  logic             vdirty_q, vdirty_d;
  logic             out_en;
  logic             hit_here;
  logic             use_eff;

  // Next-state logic
  always_comb begin
    hit_here   = acc_valid && (acc_idx == hand_q);
    use_eff    = use_vec[hand_q] || hit_here;
    step_valid = (state_q == SWEEP_RUN);
    take_valid = step_valid && !use_eff;
    state_d    = state_q;
    hand_d     = hand_q;
    if (state_q == SWEEP_IDLE) begin
      if (vic_req) state_d = SWEEP_RUN;
    end else begin
      hand_d = (hand_q == LAST_IDX) ? '0 : hand_q + 1'b1;
      if (take_valid) state_d = SWEEP_IDLE;
    end
    vv_d     = take_valid;
    out_en   = take_valid;
    vidx_d   = hand_q;
    vdirty_d = mod_vec[hand_q];
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SWEEP_IDLE;
      hand_q   <= '0;
      vv_q     <= 1'b0;
      vidx_q   <= '0;
      vdirty_q <= 1'b0;
    end else begin
      state_q <= state_d;
      hand_q  <= hand_d;
      vv_q    <= vv_d;
      if (out_en) begin
        vidx_q   <= vidx_d;
        vdirty_q <= vdirty_d;
      end
    end
  end

  assign sel_idx   = hand_q;
  assign vic_valid = vv_q;
  assign vic_idx   = vidx_q;
  assign vic_dirty = vdirty_q;

  // Sweep-length window tracked by a counter for the bound check
  logic [CNT_W-1:0] steps_q;
  logic             acc_seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      steps_q    <= '0;
      acc_seen_q <= 1'b0;
    end else if (state_q == SWEEP_RUN) begin
      if (steps_q != CNT_MAX) steps_q <= steps_q + 1'b1;
      if (acc_valid) acc_seen_q <= 1'b1;
    end else begin
      steps_q    <= '0;
      acc_seen_q <= 1'b0;
    end
  end

  AST_SWEEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SWEEP_RUN && !acc_seen_q) |-> (steps_q <= STEP_LIM)); // R7
  AST_HAND_AFTER_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
    vv_q |-> (hand_q == ((vidx_q == LAST_IDX) ? '0 : vidx_q + 1'b1))); // R6
  AST_HAND_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SWEEP_IDLE) |=> $stable(hand_q)); // R6
  AST_VICTIM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    vv_q |=> !vv_q); // R4
  AST_VICTIM_MARKS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    vv_q |-> (!use_vec[vidx_q] && !mod_vec[vidx_q])); // R8
  AST_REQ_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SWEEP_RUN && !take_valid) |=> (state_q == SWEEP_RUN)); // R10

endmodule

// File: rtl/clock_victim_sel.sv
`timescale 1ns/1ps
module clock_victim_sel #(
  parameter int NUM_FRAMES = 8,
  parameter int IDX_W      = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic             acc_write,
  input  logic             vic_req,
  output logic             vic_valid,
  output logic [IDX_W-1:0] vic_idx,
  output logic             vic_dirty
);

  logic [NUM_FRAMES-1:0] use_vec;
  logic [NUM_FRAMES-1:0] mod_vec;
  logic                  step_valid;
  logic                  take_valid;
  logic [IDX_W-1:0]      sel_idx;

  victim_frame_bits #(
    .NUM_FRAMES (NUM_FRAMES),
    .IDX_W      (IDX_W)
  ) u_bits (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_idx    (acc_idx),
    .acc_write  (acc_write),
    .step_valid (step_valid),
    .take_valid (take_valid),
    .sel_idx    (sel_idx),
    .use_vec    (use_vec),
    .mod_vec    (mod_vec)
  );

  victim_hand_ctrl #(
    .NUM_FRAMES (NUM_FRAMES),
    .IDX_W      (IDX_W)
  ) u_hand (
    .clk        (clk),
    .rst_n      (rst_n),
    .vic_req    (vic_req),
    .acc_valid  (acc_valid),
    .acc_idx    (acc_idx),
    .use_vec    (use_vec),
    .mod_vec    (mod_vec),
    .step_valid (step_valid),
    .take_valid (take_valid),
    .sel_idx    (sel_idx),
    .vic_valid  (vic_valid),
    .vic_idx    (vic_idx),
    .vic_dirty  (vic_dirty)
  );

endmodule

// File: tb/clock_victim_sel_tb.sv
`timescale 1ns/1ps
module clock_victim_sel_tb;

  localparam int NF    = 8;
  localparam int IW    = 3;
  localparam int WD_NS = 150000 * 8;

  typedef struct packed {
    logic       kind;   // 0 = access, 1 = victim request
    logic [3:0] idx;
    logic       wr;
    logic [3:0] e_idx;
    logic       e_dirty;
    logic [4:0] e_cyc;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 4'd0, 1'b0, 4'd0, 1'b0, 5'd1},  // fresh after reset
    '{1'b0, 4'd1, 1'b1, 4'd0, 1'b0, 5'd0},
    '{1'b0, 4'd2, 1'b0, 4'd0, 1'b0, 5'd0},
    '{1'b1, 4'd0, 1'b0, 4'd3, 1'b0, 5'd3},  // passes 1,2
    '{1'b0, 4'd5, 1'b1, 4'd0, 1'b0, 5'd0},
    '{1'b0, 4'd4, 1'b0, 4'd0, 1'b0, 5'd0},
    '{1'b1, 4'd0, 1'b0, 4'd6, 1'b0, 5'd3},  // passes 4,5
    '{1'b1, 4'd0, 1'b0, 4'd7, 1'b0, 5'd1},
    '{1'b1, 4'd0, 1'b0, 4'd0, 1'b0, 5'd1},  // wrap 7 -> 0
    '{1'b1, 4'd0, 1'b0, 4'd1, 1'b1, 5'd1},  // written earlier
    '{1'b1, 4'd0, 1'b0, 4'd2, 1'b0, 5'd1},
    '{1'b0, 4'd3, 1'b1, 4'd0, 1'b0, 5'd0},
    '{1'b1, 4'd0, 1'b0, 4'd4, 1'b0, 5'd2},  // passes 3
    '{1'b1, 4'd0, 1'b0, 4'd5, 1'b1, 5'd1}
  };

  logic          clk;
  logic          rst_n;
  logic          acc_valid;
  logic [IW-1:0] acc_idx;
  logic          acc_write;
  logic          vic_req;
  logic          vic_valid;
  logic [IW-1:0] vic_idx;
  logic          vic_dirty;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  clock_victim_sel #(.NUM_FRAMES(NF)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_idx   (acc_idx),
    .acc_write (acc_write),
    .vic_req   (vic_req),
    .vic_valid (vic_valid),
    .vic_idx   (vic_idx),
    .vic_dirty (vic_dirty)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check_eq(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic do_access(input int idx, input bit wr);
    @(negedge clk);
    acc_valid = 1'b1;
    acc_idx   = IW'(idx);
    acc_write = wr;
    @(negedge clk);
    acc_valid = 1'b0;
    acc_write = 1'b0;
  endtask

  task automatic do_victim(input string t_idx, input string t_dirty, input string t_cyc,
                           input int e_idx, input int e_dirty, input int e_cyc,
                           input bit coll, input int cidx, input bit stray);
    int cyc;
    @(negedge clk);
    vic_req = 1'b1;
    @(negedge clk);
    vic_req = 1'b0;
    if (coll) begin
      acc_valid = 1'b1;
      acc_idx   = IW'(cidx);
      acc_write = 1'b0;
    end
    cyc = 0;
    while (vic_valid !== 1'b1 && cyc < 64) begin
      @(negedge clk);
      cyc++;
      if (coll && cyc == 1) acc_valid = 1'b0;
      if (stray && cyc == 2) vic_req = 1'b1;
      if (stray && cyc == 3) vic_req = 1'b0;
    end
    vic_req   = 1'b0;
    acc_valid = 1'b0;
    if (vic_valid !== 1'b1) begin
      check_eq(t_cyc, "sweep never finished", 0, 1);
    end else begin
      check_eq(t_idx, "victim index", int'(vic_idx), e_idx);
      check_eq(t_dirty, "victim dirty", int'(vic_dirty), e_dirty);
      check_eq(t_cyc, "sweep cycles", cyc, e_cyc);
    end
  endtask

  function automatic void summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endfunction

  initial begin
    #(WD_NS);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    acc_valid = 1'b0;
    acc_idx   = '0;
    acc_write = 1'b0;
    vic_req   = 1'b0;
    repeat (3) @(negedge clk);
    check_eq("R1", "vic_valid in reset", int'(vic_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1", "vic_valid after reset", int'(vic_valid), 0);

    // Table walk: R1 first entry, R2/R3 pass-overs, R4/R6 choices, R5 dirty
    for (int k = 0; k < NVEC; k++) begin
      if (VEC[k].kind == 1'b0)
        do_access(int'(VEC[k].idx), VEC[k].wr);
      else
        do_victim("R4/R6", "R5", "R2/R3", int'(VEC[k].e_idx), int'(VEC[k].e_dirty),
                  int'(VEC[k].e_cyc), 1'b0, 0, 1'b0);
    end

    // R7: every frame marked, hand at 6 -> full pass then frame 6, N+1 steps
    for (int f = 0; f < NF; f++) do_access(f, 1'b0);
    do_victim("R7", "R7", "R7", 6, 0, NF + 1, 1'b0, 0, 1'b0);

    // R8: frame 1 was dirty, choosing it earlier cleared the mark
    do_victim("R6", "R8", "R8", 7, 0, 1, 1'b0, 0, 1'b0);
    do_victim("R6", "R8", "R8", 0, 0, 1, 1'b0, 0, 1'b0);
    do_victim("R8", "R8", "R8", 1, 0, 1, 1'b0, 0, 1'b0);

    // R9: access to frame 2 in the cycle of its sweep step
    do_victim("R9", "R5", "R9", 3, 1, 2, 1'b1, 2, 1'b0);
    for (int f = 4; f < 10; f++) do_access(f % NF, 1'b0);
    do_victim("R9", "R8", "R9", 3, 0, 8, 1'b0, 0, 1'b0);

    // R10: a second request raised mid-sweep is ignored
    for (int f = 4; f < 7; f++) do_access(f, 1'b0);
    do_victim("R10", "R10", "R10", 7, 0, 4, 1'b0, 0, 1'b1);
    for (int w = 0; w < 5; w++) begin
      @(negedge clk);
      check_eq("R10", "no extra vic_valid", int'(vic_valid), 0);
    end
    do_victim("R10", "R10", "R10", 0, 0, 1, 1'b0, 0, 1'b0);

    done = 1;
    summary();
    $finish;
  end

endmodule